// File: doc/BRIEF.md
# Accumulator Arithmetic Logic Unit

This block is the arithmetic and logic engine of an 8-bit accumulator processor core. The core's decoder presents an operation code, the current accumulator, an already fetched second operand byte, the B register and the carry (CY), auxiliary-carry (AC) and overflow (OV) flags, and raises `start` for one cycle. The block returns the new accumulator, the new B register, a rewritten operand byte for the memory write-back path, and the three updated flags.

Most operations finish in one clock: the results register on the edge that samples `start`, and `done` pulses in the following cycle. Multiply and divide run on a shared iterative shift engine for a fixed four cycles. While that engine works, `busy` is high and any new `start` is ignored. The outputs keep their previous values until `done` marks the new result.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op` are ADD=0, ADDC=1, SUBB=2, INC=3, DEC=4, AND=5, OR=6, XOR=7, CLR=8, CPL=9, RL=10, RLC=11, RR=12, RRC=13, SWAP=14, XCHD=15, DA=16, MUL=17, DIV=18. For any code other than 17 or 18, a `start` accepted while `busy` is low updates all outputs on that clock edge and pulses `done` for exactly one cycle. A code from 19 to 31 returns A and every flag unchanged. The outputs never change in a cycle where `done` is low.
- R2: ADD returns A+operand and ADDC returns A+operand+CY. Both set CY to the carry out of bit 7, AC to the carry out of bit 3, and OV when two operands of equal sign give a result of the other sign.
- R3: SUBB returns A-operand-CY. CY is set to the borrow out of bit 7 and AC to the borrow out of bit 3. OV is set when operands of differing sign give a result whose sign differs from A.
- R4: INC and DEC add or subtract one from A, wrapping modulo 256, and leave CY, AC and OV as given.
- R5: AND, OR and XOR combine A with the operand. CLR returns zero and CPL returns the bitwise inverse of A. None of these alters a flag.
- R6: RL and RR rotate the 8 bits of A by one place, left or right, and leave CY alone. RLC and RRC rotate the 9-bit ring formed by CY and A, and CY takes the bit shifted out.
- R7: SWAP exchanges the two nibbles of A. XCHD returns A with its low nibble replaced by the operand's low nibble, and returns on `mem_out` the operand with its low nibble replaced by A's old low nibble.
- R8: DA first adds 0x06 when A[3:0] > 9 or AC is set. It then adds 0x60 when the partial result's bits 7:4 exceed 9, CY is set, or the first step carried out. CY becomes set if either step carries out of bit 7 and is never cleared. AC and OV are unchanged.
- R9: MUL places the 16-bit product A*B with its high byte in B and its low byte in A. It clears CY, sets OV exactly when the product exceeds 255, and leaves AC unchanged.
- R10: DIV places A/B in A and A mod B in B, clearing CY and OV. With B equal to zero it sets OV and clears CY, and A and B are unspecified. AC is unchanged.
- R11: An accepted MUL or DIV holds `busy` high for 3 cycles. The result and a one-cycle `done` appear 4 cycles after the accepting edge, with `busy` low. A `start` seen while `busy` is high has no effect.
- R12: While `rst_n` is low, all data and flag outputs, `busy` and `done` are zero. This also holds when reset arrives in the middle of a multiply.
- R13: For every code except 17 and 18, `b_out` equals `b_in`. For every code except 15, `mem_out` equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation this cycle |
| op | input | 5 | Operation code (see R1) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand byte |
| b_in | input | 8 | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| ov_in | input | 1 | Current overflow flag |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| mem_out | output | 8 | Operand byte to write back |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | Results valid, one-cycle pulse |

## Verification
Some properties are checked on every cycle. The outputs stay still between `done` pulses and `busy` and `done` are never high together. A single-cycle request produces `done` one cycle later, and a multiply or divide produces `done` exactly on its fourth cycle. After a multiply, CY is clear and OV agrees with a non-zero high byte. After a divide by a non-zero B, both flags are clear and the remainder is smaller than the divisor that was captured. The exact arithmetic values appear only in the bench's scenarios: sums, borrows, half-carries, the decimal-adjust correction paths, rotate rings and products. The same goes for start being ignored during busy and reset arriving in the middle of an operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RR   = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_XCHD = 5'd15,
    OP_DA   = 5'd16,
    OP_MUL  = 5'd17,
    OP_DIV  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] opnd,
  input  logic         cy_in,
  input  logic         ac_in,
  input  logic         ov_in,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out,
  output logic         ov_out
);
  localparam int NIB = 4;

  logic [W:0]   full;
  logic [NIB:0] half;
  logic         cin;

  always_comb begin
    res    = a;
    cy_out = cy_in;
    ac_out = ac_in;
    ov_out = ov_in;
    full   = '0;
    half   = '0;
    cin    = 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        cin    = (op == OP_ADDC) & cy_in;
        full   = {1'b0, a} + {1'b0, opnd} + {{W{1'b0}}, cin};
        half   = {1'b0, a[NIB-1:0]} + {1'b0, opnd[NIB-1:0]} + {{NIB{1'b0}}, cin};
        res    = full[W-1:0];
        cy_out = full[W];
        ac_out = half[NIB];
        ov_out = (a[W-1] == opnd[W-1]) && (full[W-1] != a[W-1]);
      end
      OP_SUBB: begin
        full   = {1'b0, a} - {1'b0, opnd} - {{W{1'b0}}, cy_in};
        half   = {1'b0, a[NIB-1:0]} - {1'b0, opnd[NIB-1:0]} - {{NIB{1'b0}}, cy_in};
        res    = full[W-1:0];
        cy_out = full[W];
        ac_out = half[NIB];
        ov_out = (a[W-1] != opnd[W-1]) && (full[W-1] != a[W-1]);
      end
      OP_INC: res = a + W'(1);
      OP_DEC: res = a - W'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] opnd,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] res,
  output logic [W-1:0] mem,
  output logic         cy_out
);
  localparam int NIB = 4;

  logic [W:0] adj;

  always_comb begin
    res    = a;
    mem    = opnd;
    cy_out = cy_in;
    adj    = {1'b0, a};
    case (op)
      OP_AND:  res = a & opnd;
      OP_OR:   res = a | opnd;
      OP_XOR:  res = a ^ opnd;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RLC: begin
        res    = {a[W-2:0], cy_in};
        cy_out = a[W-1];
      end
      OP_RRC: begin
        res    = {cy_in, a[W-1:1]};
        cy_out = a[0];
      end
      OP_SWAP: res = {a[NIB-1:0], a[W-1:NIB]};
      OP_XCHD: begin
        res = {a[W-1:NIB], opnd[NIB-1:0]};
        mem = {opnd[W-1:NIB], a[NIB-1:0]};
      end
      OP_DA: begin
        if (a[NIB-1:0] > 4'd9 || ac_in)
          adj = adj + (W+1)'(6);
        if (adj[W-1:NIB] > 4'd9 || cy_in || adj[W])
          adj = adj + (W+1)'(8'h60);
        res    = adj[W-1:0];
        cy_out = cy_in | adj[W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         is_div,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         last,
  output logic         div_mode,
  output logic         div_zero,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int BPS = W / STEPS;
  localparam int CW  = (STEPS > 2) ? $clog2(STEPS) : 1;

  logic [W-1:0]  hi_q, lo_q, dvs_q, hi_n, lo_n, dvs_n;
  logic          div_q, div_n, busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;

  logic [W-1:0] hv, lv, dv;
  logic         mv;
  logic [W:0]   rem_t, sum_t;

  // one engine step: BPS shift-subtract or shift-add iterations
  always_comb begin
    hv    = go ? '0 : hi_q;
    lv    = go ? a : lo_q;
    dv    = go ? b : dvs_q;
    mv    = go ? is_div : div_q;
    rem_t = '0;
    sum_t = '0;
    for (int i = 0; i < BPS; i++) begin
      if (mv) begin
        rem_t = {hv, lv[W-1]};
        lv    = {lv[W-2:0], 1'b0};
        if (rem_t >= {1'b0, dv}) begin
          rem_t = rem_t - {1'b0, dv};
          lv[0] = 1'b1;
        end
        hv = rem_t[W-1:0];
      end else begin
        sum_t = {1'b0, hv} + (lv[0] ? {1'b0, dv} : '0);
        lv    = {sum_t[0], lv[W-1:1]};
        hv    = sum_t[W:1];
      end
    end
  end

  assign last = busy_q && (cnt_q == CW'(STEPS - 1));

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    dvs_n  = dvs_q;
    div_n  = div_q;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (go) begin
      hi_n   = hv;
      lo_n   = lv;
      dvs_n  = b;
      div_n  = is_div;
      busy_n = 1'b1;
      cnt_n  = CW'(1);
    end else if (busy_q) begin
      hi_n  = hv;
      lo_n  = lv;
      cnt_n = cnt_q + CW'(1);
      if (last)
        busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      dvs_q  <= '0;
      div_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      dvs_q  <= dvs_n;
      div_q  <= div_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy     = busy_q;
  assign div_mode = div_q;
  assign div_zero = (dvs_q == '0);
  assign res_hi   = hv;
  assign res_lo   = lv;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [4:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [W-1:0] b_in,
  input  logic         cy_in,
  input  logic         ac_in,
  input  logic         ov_in,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] b_out,
  output logic [W-1:0] mem_out,
  output logic         cy_out,
  output logic         ac_out,
  output logic         ov_out,
  output logic         busy,
  output logic         done
);
  logic rst_meta_q, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  alu_op_e op_e;
  logic    is_arith, is_md, accept, md_go;

  assign op_e     = alu_op_e'(op);
  assign is_arith = (op_e == OP_ADD) || (op_e == OP_ADDC) || (op_e == OP_SUBB) ||
                    (op_e == OP_INC) || (op_e == OP_DEC);
  assign is_md    = (op_e == OP_MUL) || (op_e == OP_DIV);

  logic         md_busy, md_last, md_div, md_dz;
  logic [W-1:0] md_hi, md_lo;

  assign accept = start && !md_busy;
  assign md_go  = accept && is_md;

  logic [W-1:0] as_res;
  logic         as_cy, as_ac, as_ov;
  logic [W-1:0] bo_res, bo_mem;
  logic         bo_cy;

  acc_alu_addsub #(.W(W)) u_addsub (
    .op(op_e), .a(acc_in), .opnd(opnd_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .res(as_res), .cy_out(as_cy), .ac_out(as_ac), .ov_out(as_ov)
  );

  acc_alu_bitops #(.W(W)) u_bitops (
    .op(op_e), .a(acc_in), .opnd(opnd_in), .cy_in(cy_in), .ac_in(ac_in),
    .res(bo_res), .mem(bo_mem), .cy_out(bo_cy)
  );

  acc_alu_muldiv #(.W(W), .STEPS(STEPS)) u_muldiv (
    .clk(clk), .rst_n(rst_q), .go(md_go), .is_div(op_e == OP_DIV),
    .a(acc_in), .b(b_in), .busy(md_busy), .last(md_last),
    .div_mode(md_div), .div_zero(md_dz), .res_hi(md_hi), .res_lo(md_lo)
  );

  logic [W-1:0] a_q, b_q, m_q, pm_q, a_n, b_n, m_n, pm_n;
  logic         cy_q, ac_q, ov_q, done_q, pac_q;
  logic         cy_n, ac_n, ov_n, done_n, pac_n;

  always_comb begin
    a_n    = a_q;
    b_n    = b_q;
    m_n    = m_q;
    cy_n   = cy_q;
    ac_n   = ac_q;
    ov_n   = ov_q;
    pac_n  = pac_q;
    pm_n   = pm_q;
    done_n = 1'b0;
    if (md_last) begin
      a_n    = md_lo;
      b_n    = md_hi;
      m_n    = pm_q;
      cy_n   = 1'b0;
      ac_n   = pac_q;
      ov_n   = md_div ? md_dz : (md_hi != '0);
      done_n = 1'b1;
    end else if (accept) begin
      if (is_md) begin
        pac_n = ac_in;
        pm_n  = opnd_in;
      end else begin
        a_n    = is_arith ? as_res : bo_res;
        b_n    = b_in;
        m_n    = bo_mem;
        cy_n   = is_arith ? as_cy : bo_cy;
        ac_n   = is_arith ? as_ac : ac_in;
        ov_n   = is_arith ? as_ov : ov_in;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      pm_q   <= '0;
      cy_q   <= 1'b0;
      ac_q   <= 1'b0;
      ov_q   <= 1'b0;
      pac_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_n;
      b_q    <= b_n;
      m_q    <= m_n;
      pm_q   <= pm_n;
      cy_q   <= cy_n;
      ac_q   <= ac_n;
      ov_q   <= ov_n;
      pac_q  <= pac_n;
      done_q <= done_n;
    end
  end

  assign acc_out = a_q;
  assign b_out   = b_q;
  assign mem_out = m_q;
  assign cy_out  = cy_q;
  assign ac_out  = ac_q;
  assign ov_out  = ov_q;
  assign busy    = md_busy;
  assign done    = done_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int STEPS = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [4:0]   op,
  input logic [W-1:0] b_in,
  input logic [W-1:0] acc_out,
  input logic [W-1:0] b_out,
  input logic         cy_out,
  input logic         ov_out,
  input logic         busy,
  input logic         done
);
  localparam int CCW = $clog2(STEPS + 1);

  logic           acc_md, pend_q, rdiv_q;
  logic [W-1:0]   rb_q;
  logic [CCW-1:0] cnt_q;

  assign acc_md = (op == OP_MUL) || (op == OP_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rdiv_q <= 1'b0;
      rb_q   <= '0;
      cnt_q  <= '0;
    end else if (start && !busy) begin
      pend_q <= acc_md;
      rdiv_q <= (op == OP_DIV);
      rb_q   <= b_in;
      cnt_q  <= CCW'(1);
    end else if (pend_q) begin
      cnt_q <= cnt_q + CCW'(1);
      if (done)
        pend_q <= 1'b0;
    end
  end

  // R1: results only move on a done pulse
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(acc_out) && $stable(b_out) && $stable(cy_out) && $stable(ov_out)));

  // R1: single-cycle ops complete on the next cycle
  a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !acc_md) |=> done);

  // R11: busy and done are exclusive
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R11: multiply/divide done lands exactly on cycle STEPS
  a_r11_md_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && done) |-> (cnt_q == CCW'(STEPS)));

  a_r11_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q < CCW'(STEPS)) |-> !done);

  // R9: multiply flag rules
  a_r9_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && done && !rdiv_q) |-> (!cy_out && (ov_out == (b_out != '0))));

  // R10: divide by non-zero
  a_r10_div_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && done && rdiv_q && rb_q != '0) |-> (!cy_out && !ov_out && b_out < rb_q));

  // R10: divide by zero
  a_r10_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && done && rdiv_q && rb_q == '0) |-> (ov_out && !cy_out));

  // R12: idle while reset is held
  always @(posedge clk) begin
    if (!rst_n)
      a_r12_reset_idle: assert (!busy && !done && acc_out == '0);
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_q), .start(start), .op(op), .b_in(b_in),
  .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out),
  .busy(busy), .done(done)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] acc_out, b_out, mem_out;
  logic       cy_out, ac_out, ov_out, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_in(acc_in),
    .opnd_in(opnd_in), .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .acc_out(acc_out), .b_out(b_out), .mem_out(mem_out), .cy_out(cy_out),
    .ac_out(ac_out), .ov_out(ov_out), .busy(busy), .done(done)
  );

  // {req, op, a, opnd, b, cy/ac/ov in, exp a, exp b, exp mem, exp cy/ac/ov}
  localparam int NV = 37;
  localparam logic [62:0] VEC [NV] = '{
    {4'd2,  5'd0,  8'h3A, 8'h25, 8'h11, 3'b111, 8'h5F, 8'h11, 8'h25, 3'b000}, // R2 plain add, R13
    {4'd2,  5'd0,  8'h7F, 8'h01, 8'h11, 3'b000, 8'h80, 8'h11, 8'h01, 3'b011}, // R2 signed overflow
    {4'd2,  5'd0,  8'hFF, 8'h01, 8'h11, 3'b000, 8'h00, 8'h11, 8'h01, 3'b110}, // R2 carry out
    {4'd2,  5'd1,  8'h80, 8'h80, 8'h11, 3'b100, 8'h01, 8'h11, 8'h80, 3'b101}, // R2 addc neg+neg
    {4'd2,  5'd1,  8'h0E, 8'h01, 8'h11, 3'b100, 8'h10, 8'h11, 8'h01, 3'b010}, // R2 addc half carry
    {4'd3,  5'd2,  8'h50, 8'h20, 8'h11, 3'b011, 8'h30, 8'h11, 8'h20, 3'b000}, // R3
    {4'd3,  5'd2,  8'h10, 8'h01, 8'h11, 3'b100, 8'h0E, 8'h11, 8'h01, 3'b010}, // R3 half borrow
    {4'd3,  5'd2,  8'h00, 8'h01, 8'h11, 3'b000, 8'hFF, 8'h11, 8'h01, 3'b110}, // R3 borrow
    {4'd3,  5'd2,  8'h80, 8'h01, 8'h11, 3'b000, 8'h7F, 8'h11, 8'h01, 3'b011}, // R3 overflow
    {4'd3,  5'd2,  8'h7F, 8'hFF, 8'h11, 3'b000, 8'h80, 8'h11, 8'hFF, 3'b101}, // R3 overflow+borrow
    {4'd4,  5'd3,  8'hFF, 8'h5A, 8'h11, 3'b101, 8'h00, 8'h11, 8'h5A, 3'b101}, // R4 inc wrap
    {4'd4,  5'd4,  8'h00, 8'h5A, 8'h11, 3'b010, 8'hFF, 8'h11, 8'h5A, 3'b010}, // R4 dec wrap
    {4'd5,  5'd5,  8'hF0, 8'h3C, 8'h11, 3'b111, 8'h30, 8'h11, 8'h3C, 3'b111}, // R5 and
    {4'd5,  5'd6,  8'h0F, 8'hA0, 8'h11, 3'b000, 8'hAF, 8'h11, 8'hA0, 3'b000}, // R5 or
    {4'd5,  5'd7,  8'hFF, 8'h5A, 8'h11, 3'b010, 8'hA5, 8'h11, 8'h5A, 3'b010}, // R5 xor
    {4'd5,  5'd8,  8'h77, 8'h00, 8'h11, 3'b101, 8'h00, 8'h11, 8'h00, 3'b101}, // R5 clr
    {4'd5,  5'd9,  8'h5A, 8'h00, 8'h11, 3'b000, 8'hA5, 8'h11, 8'h00, 3'b000}, // R5 cpl
    {4'd6,  5'd10, 8'h81, 8'h00, 8'h11, 3'b000, 8'h03, 8'h11, 8'h00, 3'b000}, // R6 rl
    {4'd6,  5'd11, 8'h81, 8'h00, 8'h11, 3'b000, 8'h02, 8'h11, 8'h00, 3'b100}, // R6 rlc out
    {4'd6,  5'd11, 8'h40, 8'h00, 8'h11, 3'b100, 8'h81, 8'h11, 8'h00, 3'b000}, // R6 rlc in
    {4'd6,  5'd12, 8'h01, 8'h00, 8'h11, 3'b000, 8'h80, 8'h11, 8'h00, 3'b000}, // R6 rr
    {4'd6,  5'd13, 8'h01, 8'h00, 8'h11, 3'b000, 8'h00, 8'h11, 8'h00, 3'b100}, // R6 rrc out
    {4'd6,  5'd13, 8'h02, 8'h00, 8'h11, 3'b111, 8'h81, 8'h11, 8'h00, 3'b011}, // R6 rrc in
    {4'd7,  5'd14, 8'hA5, 8'h00, 8'h11, 3'b000, 8'h5A, 8'h11, 8'h00, 3'b000}, // R7 swap
    {4'd7,  5'd15, 8'h12, 8'hAB, 8'h11, 3'b000, 8'h1B, 8'h11, 8'hA2, 3'b000}, // R7 xchd
    {4'd8,  5'd16, 8'h9B, 8'h00, 8'h11, 3'b000, 8'h01, 8'h11, 8'h00, 3'b100}, // R8 both steps
    {4'd8,  5'd16, 8'h10, 8'h00, 8'h11, 3'b010, 8'h16, 8'h11, 8'h00, 3'b010}, // R8 ac path
    {4'd8,  5'd16, 8'h25, 8'h00, 8'h11, 3'b100, 8'h85, 8'h11, 8'h00, 3'b100}, // R8 cy path
    {4'd8,  5'd16, 8'h45, 8'h00, 8'h11, 3'b000, 8'h45, 8'h11, 8'h00, 3'b000}, // R8 no change
    {4'd8,  5'd16, 8'hFA, 8'h00, 8'h11, 3'b000, 8'h60, 8'h11, 8'h00, 3'b100}, // R8 first-step carry
    {4'd1,  5'd19, 8'h33, 8'h44, 8'h11, 3'b101, 8'h33, 8'h11, 8'h44, 3'b101}, // R1 unused code
    {4'd9,  5'd17, 8'h50, 8'h5A, 8'hA0, 3'b110, 8'h00, 8'h32, 8'h5A, 3'b011}, // R9 big product
    {4'd9,  5'd17, 8'h0C, 8'h00, 8'h0A, 3'b000, 8'h78, 8'h00, 8'h00, 3'b000}, // R9 small product
    {4'd9,  5'd17, 8'hFF, 8'h00, 8'hFF, 3'b000, 8'h01, 8'hFE, 8'h00, 3'b001}, // R9 max
    {4'd10, 5'd18, 8'hFB, 8'h00, 8'h12, 3'b101, 8'h0D, 8'h11, 8'h00, 3'b000}, // R10
    {4'd10, 5'd18, 8'h07, 8'h00, 8'h09, 3'b010, 8'h00, 8'h07, 8'h00, 3'b010}, // R10 a<b
    {4'd10, 5'd18, 8'hFF, 8'h00, 8'h01, 3'b000, 8'hFF, 8'h00, 8'h00, 3'b000}  // R10 by one
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, return cycles from accepting edge until done is seen
  task automatic run_op(input logic [4:0] o, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] b, input logic [2:0] f, output int cyc);
    @(negedge clk);
    op = o; acc_in = a; opnd_in = d; b_in = b;
    {cy_in, ac_in, ov_in} = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 12) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset outputs", {acc_out, b_out, mem_out, cy_out, ac_out, ov_out, busy, done},
          32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      logic [4:0]  vop;
      int          req;
      v   = VEC[i];
      vop = v[58:54];
      req = int'(v[62:59]);
      run_op(vop, v[53:46], v[45:38], v[37:30], v[29:27], cyc);
      check($sformatf("R%0d vec %0d acc", req, i), acc_out, v[26:19]);
      check($sformatf("R%0d vec %0d b (R13)", req, i), b_out, v[18:11]);
      check($sformatf("R%0d vec %0d mem (R13)", req, i), mem_out, v[10:3]);
      check($sformatf("R%0d vec %0d flags", req, i), {cy_out, ac_out, ov_out}, v[2:0]);
      // R11 / R1 latency
      check($sformatf("R11 vec %0d latency", i), cyc,
            (vop == 5'd17 || vop == 5'd18) ? 4 : 1);
      @(negedge clk);
      check($sformatf("R1 vec %0d done pulse width", i), done, 1'b0);
    end

    // R10: divide by zero flags
    run_op(5'd18, 8'h42, 8'h00, 8'h00, 3'b100, cyc);
    check("R10 div0 cy/ov", {cy_out, ov_out}, 2'b01);
    check("R10 div0 latency", cyc, 4);

    // R11: busy window and ignored start
    @(negedge clk);
    op = 5'd17; acc_in = 8'h10; opnd_in = 8'h00; b_in = 8'h10; {cy_in, ac_in, ov_in} = 3'b000;
    start = 1'b1;
    @(negedge clk);
    check("R11 busy after accept", busy, 1'b1);
    op = 5'd0; acc_in = 8'h01; opnd_in = 8'h01;
    @(negedge clk);
    check("R11 busy cycle 2", {busy, done}, 2'b10);
    @(negedge clk);
    check("R11 busy cycle 3", {busy, done}, 2'b10);
    start = 1'b0;
    @(negedge clk);
    check("R11 done on cycle 4", {busy, done}, 2'b01);
    check("R11 product kept over ignored start", {b_out, acc_out}, 16'h0100);
    check("R9 overflow 0x10*0x10", ov_out, 1'b1);
    @(negedge clk);
    check("R11 ignored start made no result", {done, acc_out}, 9'h000);

    // R12: reset in the middle of a multiply
    run_op(5'd3, 8'h7E, 8'h00, 8'h00, 3'b000, cyc);
    @(negedge clk);
    op = 5'd17; acc_in = 8'h20; b_in = 8'h20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12 mid-op reset", {acc_out, busy, done}, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 idle after reset", {busy, done}, 2'b00);

    // R2 back-to-back single ops
    run_op(5'd0, 8'h01, 8'h02, 8'h00, 3'b000, cyc);
    check("R2 first of pair", acc_out, 8'h03);
    run_op(5'd1, 8'h03, 8'h04, 8'h00, 3'b100, cyc);
    check("R2 second of pair", acc_out, 8'h08);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule